// File: doc/BRIEF.md
# NAND flash command sequencer

This block runs raw 8-bit NAND flash transactions. Software loads the address registers, then writes one control word. Enable bits in that word pick which phases run: an opening command byte, column address bytes, row address bytes, a closing command byte, and a data transfer of up to four bytes. The phases always run in that order. Strobe timing comes from a packed wait register, and the address byte counts come from a configuration register.

The start bit reads as set while the operation runs and clears when it finishes, so software polls it. Chip select can be kept asserted after an operation ends. This lets a page read be issued as one addressing word followed by several data words, and the last word releases chip select. The ready/busy pin of the flash is synchronised and shown in the control word. An error flag records control writes that were rejected.

Register offsets on the 3-bit address: 0 control, 1 column, 2 row, 3 data, 4 config, 5 wait.

Top module: `nfc_cmd_seq`

## Requirements
- R1: Writing the control word with bit 31 set while idle starts an operation. Bit 31 reads 1 from the cycle after the write until the operation ends, then reads 0.
- R2: Phases run only when enabled, and always in this order: command 1 (bit 16, byte from bits 7:0, CLE high), column (bit 17), row (bit 18), command 2 (bit 19, byte from bits 15:8, CLE high), then data.
- R3: Address bytes are sent with ALE high, least significant byte first. Config bits 5:4 hold the column byte count minus one, and bits 7:6 hold the row byte count minus one.
- R4: Bit 24 (single-address mode) sends exactly one ALE byte, taken from column register bits 7:0, in place of the column phase.
- R5: Bit 20 reads data and bit 21 writes data. Bits 29:28 = n move n+1 bytes, and byte k travels in data register lane k (bits 8k+7:8k). A read clears the data register first, so unused lanes read 0.
- R6: Wait register fields, each lasting value+1 clock cycles: [5:0] strobe low, [11:6] strobe high, [17:12] setup before the strobe, [23:18] end hold, [29:24] wait after command 2.
- R7: Chip select (active low) is asserted from the first phase. After the operation it stays asserted if bit 30 is set and is released otherwise. An operation that has only command 1, with byte 0xFF and bit 30 clear, runs without asserting chip select.
- R8: Control bit 26 follows the ready/busy pin through a two-flop synchroniser. Control bit 27 reads 1 only when an error is latched and ready is high.
- R9: A control write while busy is ignored and latches the error. The next accepted start clears the error.
- R10: Column, row, data, config and wait writes are ignored while busy.
- R11: Both strobes idle high, CLE and ALE are never high together, and the data bus is driven only for command, address and write bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| nand_ce_no | output | 1 | Chip select, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_i | input | 1 | Flash ready/busy, high = ready |

## Verification
A bad phase pointer or byte index appears on the bus at the next rising edge of the write strobe, as a wrong CLE/ALE flag or a wrong byte. The bench flash model logs every such edge. A bad timer load changes the strobe-low width and the number of cycles the start bit stays set, and both are counted exactly. Lane or chip-select errors show as soon as the data register or the chip-select pin is read after the operation completes.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    PH_CMD1 = 3'd0,
    PH_COL  = 3'd1,
    PH_ROW  = 3'd2,
    PH_CMD2 = 3'd3,
    PH_WB   = 3'd4,
    PH_DATA = 3'd5,
    PH_HOLD = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_WAIT
  } step_e;

  typedef struct packed {
    logic       hold;
    logic [1:0] size;
    logic       spec;
    logic       wr;
    logic       rd;
    logic       cmd2_en;
    logic       row_en;
    logic       col_en;
    logic       cmd1_en;
    logic [7:0] cmd2;
    logic [7:0] cmd1;
  } ctl_t;

  // control word bit positions are software visible
  localparam int unsigned B_START = 31;
  localparam int unsigned B_HOLD  = 30;
  localparam int unsigned B_ERR   = 27;
  localparam int unsigned B_RDY   = 26;

  function automatic ctl_t ctl_decode(logic [31:0] w);
    ctl_t c;
    c.hold    = w[30];
    c.size    = w[29:28];
    c.spec    = w[24];
    c.wr      = w[21];
    c.rd      = w[20];
    c.cmd2_en = w[19];
    c.row_en  = w[18];
    c.col_en  = w[17];
    c.cmd1_en = w[16];
    c.cmd2    = w[15:8];
    c.cmd1    = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] ctl_encode(ctl_t c, logic busy, logic err, logic rdy);
    return {busy, c.hold, c.size, err, rdy, 1'b0, c.spec, 2'b00, c.wr, c.rd,
            c.cmd2_en, c.row_en, c.col_en, c.cmd1_en, c.cmd2, c.cmd1};
  endfunction

endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 6,
  localparam int unsigned WAIT_W = 5 * TW,
  localparam int unsigned LANE_W = $clog2(DW / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              rdy_i,
  input  logic              rd_we_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  input  logic [7:0]        rd_byte_i,
  output logic              go_o,
  output ctl_t              ctl_o,
  output logic [DW-1:0]     col_o,
  output logic [DW-1:0]     row_o,
  output logic [7:0]        cfg_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [DW-1:0]     data_o
);
  localparam logic [2:0] A_CTL = 3'd0, A_COL = 3'd1, A_ROW = 3'd2,
                         A_DATA = 3'd3, A_CFG = 3'd4, A_WAIT = 3'd5;

  ctl_t              ctl_q;
  logic [DW-1:0]     col_q, row_q, data_q;
  logic [3:0]        cfg_q;
  logic [WAIT_W-1:0] wait_q;
  logic              go_q, err_q, busy_int, wr_ok, ctl_wr, accept;

  assign busy_int = busy_i | go_q;
  assign wr_ok    = we_i & ~busy_int;
  assign ctl_wr   = we_i & (addr_i == A_CTL);
  assign accept   = ctl_wr & ~busy_int & wdata_i[B_START];

  logic unused_bits;
  assign unused_bits = ^{wdata_i[27:25], wdata_i[23:22], wdata_i[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      data_q <= '0;
      cfg_q  <= '0;
      wait_q <= '0;
      go_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      go_q <= accept;
      if (ctl_wr && busy_int) err_q <= 1'b1;
      else if (accept)        err_q <= 1'b0;
      if (wr_ok) begin
        unique case (addr_i)
          A_CTL:  ctl_q  <= ctl_decode(wdata_i[31:0]);
          A_COL:  col_q  <= wdata_i;
          A_ROW:  row_q  <= wdata_i;
          A_DATA: data_q <= wdata_i;
          A_CFG:  cfg_q  <= wdata_i[7:4];
          A_WAIT: wait_q <= wdata_i[WAIT_W-1:0];
          default: ;
        endcase
      end
      if (accept && wdata_i[20]) data_q <= '0;
      else if (rd_we_i) data_q[{rd_lane_i, 3'b000} +: 8] <= rd_byte_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTL:  rdata_o[31:0] = ctl_encode(ctl_q, busy_int, err_q & rdy_i, rdy_i);
      A_COL:  rdata_o = col_q;
      A_ROW:  rdata_o = row_q;
      A_DATA: rdata_o = data_q;
      A_CFG:  rdata_o[7:4] = cfg_q;
      A_WAIT: rdata_o[WAIT_W-1:0] = wait_q;
      default: ;
    endcase
  end

  assign go_o   = go_q;
  assign ctl_o  = ctl_q;
  assign col_o  = col_q;
  assign row_o  = row_q;
  assign cfg_o  = {cfg_q, 4'b0000};
  assign wait_o = wait_q;
  assign data_o = data_q;

  AST_CTL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && busy_int) |=> $stable(ctl_q)); // R9
  AST_ERR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && busy_int) |=> err_q); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_int |=> ($stable(cfg_q) && $stable(col_q) && $stable(wait_q))); // R10
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 6,
  localparam int unsigned WAIT_W = 5 * TW,
  localparam int unsigned LANE_W = $clog2(DW / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  ctl_t              ctl_i,
  input  logic [DW-1:0]     col_i,
  input  logic [DW-1:0]     row_i,
  input  logic [7:0]        cfg_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_we_o,
  output logic [LANE_W-1:0] rd_lane_o,
  output logic [7:0]        rd_byte_o,
  output logic              ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  input  logic [7:0]        dq_i
);
  step_e          st_q;
  phase_e         ph_q, nxt_ph;
  logic [TW-1:0]  cnt_q;
  logic [1:0]     bidx_q, last_idx;
  logic           ce_q;
  logic [6:0]     en;
  logic [3:0]     cur_pos;
  logic           byte_st, rd_data, rst_only, cnt_end;
  logic [7:0]     cur_byte;

  wire [TW-1:0] t_low  = wait_i[0*TW +: TW];
  wire [TW-1:0] t_high = wait_i[1*TW +: TW];
  wire [TW-1:0] t_set  = wait_i[2*TW +: TW];
  wire [TW-1:0] t_hold = wait_i[3*TW +: TW];
  wire [TW-1:0] t_wb   = wait_i[4*TW +: TW];

  function automatic phase_e ph_after(logic [6:0] e, logic [3:0] pos);
    phase_e r = PH_HOLD;
    for (int i = 6; i >= 0; i--)
      if (e[i] && (i + 1) > int'(pos)) r = phase_e'(i[2:0]);
    return r;
  endfunction

  assign en = {1'b1, ctl_i.rd | ctl_i.wr, ctl_i.cmd2_en, ctl_i.cmd2_en,
               ctl_i.row_en, ctl_i.col_en | ctl_i.spec, ctl_i.cmd1_en};
  assign cur_pos = (st_q == ST_IDLE) ? 4'd0 : {1'b0, ph_q} + 4'd1;
  assign nxt_ph  = ph_after(en, cur_pos);
  assign cnt_end = (cnt_q == '0);
  assign rst_only = ctl_i.cmd1_en && ctl_i.cmd1 == 8'hFF && !ctl_i.col_en &&
                    !ctl_i.row_en && !ctl_i.cmd2_en && !ctl_i.rd && !ctl_i.wr &&
                    !ctl_i.spec && !ctl_i.hold;

  always_comb begin
    unique case (ph_q)
      PH_COL:  last_idx = ctl_i.spec ? 2'd0 : cfg_i[5:4];
      PH_ROW:  last_idx = cfg_i[7:6];
      PH_DATA: last_idx = ctl_i.size;
      default: last_idx = 2'd0;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_CMD1: cur_byte = ctl_i.cmd1;
      PH_CMD2: cur_byte = ctl_i.cmd2;
      PH_COL:  cur_byte = col_i[{bidx_q, 3'b000} +: 8];
      PH_ROW:  cur_byte = row_i[{bidx_q, 3'b000} +: 8];
      PH_DATA: cur_byte = wdata_i[{bidx_q, 3'b000} +: 8];
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_CMD1;
      cnt_q  <= '0;
      bidx_q <= '0;
      ce_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          ph_q   <= nxt_ph;
          st_q   <= (nxt_ph inside {PH_WB, PH_HOLD}) ? ST_WAIT : ST_SETUP;
          cnt_q  <= (nxt_ph == PH_HOLD) ? t_hold : (nxt_ph == PH_WB) ? t_wb : t_set;
          bidx_q <= '0;
          if (!rst_only) ce_q <= 1'b1;
        end
        ST_SETUP: if (cnt_end) begin st_q <= ST_LOW; cnt_q <= t_low; end
                  else cnt_q <= cnt_q - 1'b1;
        ST_LOW:   if (cnt_end) begin st_q <= ST_HIGH; cnt_q <= t_high; end
                  else cnt_q <= cnt_q - 1'b1;
        ST_HIGH: begin
          if (!cnt_end) cnt_q <= cnt_q - 1'b1;
          else if (bidx_q != last_idx) begin
            bidx_q <= bidx_q + 1'b1;
            st_q   <= ST_SETUP;
            cnt_q  <= t_set;
          end else begin
            ph_q   <= nxt_ph;
            bidx_q <= '0;
            st_q   <= (nxt_ph inside {PH_WB, PH_HOLD}) ? ST_WAIT : ST_SETUP;
            cnt_q  <= (nxt_ph == PH_HOLD) ? t_hold : (nxt_ph == PH_WB) ? t_wb : t_set;
          end
        end
        ST_WAIT: begin
          if (!cnt_end) cnt_q <= cnt_q - 1'b1;
          else if (ph_q == PH_HOLD) begin
            st_q <= ST_IDLE;
            ce_q <= ctl_i.hold;
          end else begin
            ph_q  <= nxt_ph;
            st_q  <= (nxt_ph inside {PH_WB, PH_HOLD}) ? ST_WAIT : ST_SETUP;
            cnt_q <= (nxt_ph == PH_HOLD) ? t_hold : (nxt_ph == PH_WB) ? t_wb : t_set;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_st   = st_q inside {ST_SETUP, ST_LOW, ST_HIGH};
  assign rd_data   = (ph_q == PH_DATA) && ctl_i.rd;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_WAIT) && (ph_q == PH_HOLD) && cnt_end;
  assign rd_we_o   = (st_q == ST_LOW) && cnt_end && rd_data;
  assign rd_lane_o = LANE_W'(bidx_q);
  assign rd_byte_o = dq_i;
  assign ce_no     = ~ce_q;
  assign cle_o     = byte_st && (ph_q inside {PH_CMD1, PH_CMD2});
  assign ale_o     = byte_st && (ph_q inside {PH_COL, PH_ROW});
  assign we_no     = ~((st_q == ST_LOW) && !rd_data);
  assign re_no     = ~((st_q == ST_LOW) && rd_data);
  assign dq_oe_o   = byte_st && !rd_data;
  assign dq_o      = byte_st ? cur_byte : 8'h00;

  AST_CLE_ALE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o)); // R11
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o); // R11
  AST_ADDR_HAS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !ce_no); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R1
  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no)); // R11
endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
  import nfc_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned TW          = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WAIT_W     = 5 * TW,
  localparam int unsigned LANE_W     = $clog2(DW / 8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          nand_ce_no,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_we_no,
  output logic          nand_re_no,
  output logic [7:0]    nand_dq_o,
  output logic          nand_dq_oe_o,
  input  logic [7:0]    nand_dq_i,
  input  logic          nand_rb_i
);
  ctl_t              ctl;
  logic [DW-1:0]     col, row, data;
  logic [7:0]        cfg;
  logic [WAIT_W-1:0] waitc;
  logic              go, busy, done, rdy, rd_we;
  logic [LANE_W-1:0] rd_lane;
  logic [7:0]        rd_byte;

  nfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nand_rb_i), .q_o(rdy)
  );

  nfc_regs #(.DW(DW), .TW(TW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .busy_i(busy), .rdy_i(rdy),
    .rd_we_i(rd_we), .rd_lane_i(rd_lane), .rd_byte_i(rd_byte), .go_o(go),
    .ctl_o(ctl), .col_o(col), .row_o(row), .cfg_o(cfg), .wait_o(waitc),
    .data_o(data)
  );

  nfc_seq #(.DW(DW), .TW(TW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .ctl_i(ctl), .col_i(col),
    .row_i(row), .cfg_i(cfg), .wait_i(waitc), .wdata_i(data), .busy_o(busy),
    .done_o(done), .rd_we_o(rd_we), .rd_lane_o(rd_lane), .rd_byte_o(rd_byte),
    .ce_no(nand_ce_no), .cle_o(nand_cle_o), .ale_o(nand_ale_o),
    .we_no(nand_we_no), .re_no(nand_re_no), .dq_o(nand_dq_o),
    .dq_oe_o(nand_dq_oe_o), .dq_i(nand_dq_i)
  );

  logic unused_done;
  assign unused_done = done;
endmodule

// File: tb/nfc_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nfc_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe, rb = 1'b1;
  logic [7:0]  dq_out, dq_in;

  int checks = 0, errors = 0;
  logic [9:0] blog [64];
  int bn = 0, rd_cnt = 0, ce_cnt = 0, wel_cnt = 0;
  bit mon_en = 1'b0;

  always #2.5 clk = ~clk;

  nfc_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .nand_ce_no(ce_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_dq_o(dq_out), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in), .nand_rb_i(rb)
  );

  // flash model: log latched bytes, serve an incrementing read pattern
  assign dq_in = 8'hA0 + 8'(rd_cnt);
  always @(posedge we_n) if (mon_en && bn < 64) begin blog[bn] = {cle, ale, dq_out}; bn++; end
  always @(posedge re_n) if (mon_en) rd_cnt++;
  always @(posedge clk) if (mon_en && !ce_n) ce_cnt++;
  always @(posedge clk) if (mon_en && !we_n) wel_cnt++;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(3'd0, v);
      if (!v[31]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic chk_byte(int idx, logic [9:0] exp, string req);
    logic [9:0] act = (idx < bn) ? blog[idx] : 10'h3FF;
    check(act == exp, req, 32'(act), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    reg_rd(3'd0, v);
    check(v[31] == 1'b0, "R1 idle start bit", v, 32'h0);
    check(v[26] == 1'b1, "R8 ready after sync", 32'(v[26]), 32'h1);
    check({ce_n, we_n, re_n, cle, ale} == 5'b11100, "R11 idle bus",
          32'({ce_n, we_n, re_n, cle, ale}), 32'h1C);
  endtask

  task automatic t_cmd_addr;
    int cyc;
    reg_wr(3'd4, 32'h90);      // col 2 bytes, row 3 bytes
    reg_wr(3'd1, 32'h1234);
    reg_wr(3'd2, 32'h56789A);
    bn = 0;
    reg_wr(3'd0, 32'hC00F3000);
    wait_done(cyc);
    check(cyc == 24, "R1 busy cycles", cyc, 24);
    check(bn == 7, "R2 byte count", bn, 7);
    chk_byte(0, {2'b10, 8'h00}, "R2 cmd1");
    chk_byte(1, {2'b01, 8'h34}, "R3 col lsb");
    chk_byte(2, {2'b01, 8'h12}, "R3 col msb");
    chk_byte(3, {2'b01, 8'h9A}, "R3 row b0");
    chk_byte(4, {2'b01, 8'h78}, "R3 row b1");
    chk_byte(5, {2'b01, 8'h56}, "R3 row b2");
    chk_byte(6, {2'b10, 8'h30}, "R2 cmd2 last");
    check(ce_n == 1'b0, "R7 ce held", ce_n, 0);
  endtask

  task automatic t_read;
    int cyc;
    logic [31:0] v;
    bn = 0; rd_cnt = 0;
    reg_wr(3'd0, 32'hF0100000);
    wait_done(cyc);
    reg_rd(3'd3, v);
    check(v == 32'hA3A2A1A0, "R5 read 4 lanes", v, 32'hA3A2A1A0);
    check(ce_n == 1'b0, "R7 ce held after read", ce_n, 0);
    reg_wr(3'd0, 32'h90100000);
    wait_done(cyc);
    reg_rd(3'd3, v);
    check(v == 32'h0000A5A4, "R5 read 2 lanes", v, 32'h0000A5A4);
    check(ce_n == 1'b1, "R7 ce released", ce_n, 1);
    check(bn == 0, "R11 no write strobe on read", bn, 0);
  endtask

  task automatic t_write;
    int cyc;
    bn = 0;
    reg_wr(3'd3, 32'hDEADBEEF);
    reg_wr(3'd0, 32'hB0200000);
    wait_done(cyc);
    check(bn == 4, "R5 write bytes", bn, 4);
    chk_byte(0, {2'b00, 8'hEF}, "R5 lane0");
    chk_byte(1, {2'b00, 8'hBE}, "R5 lane1");
    chk_byte(2, {2'b00, 8'hAD}, "R5 lane2");
    chk_byte(3, {2'b00, 8'hDE}, "R5 lane3");
  endtask

  task automatic t_special;
    int cyc;
    bn = 0;
    reg_wr(3'd1, 32'h12AB);
    reg_wr(3'd0, 32'h81010090);
    wait_done(cyc);
    check(bn == 2, "R4 single addr count", bn, 2);
    chk_byte(0, {2'b10, 8'h90}, "R4 cmd");
    chk_byte(1, {2'b01, 8'hAB}, "R4 addr byte");
  endtask

  task automatic t_reset_cmd;
    int cyc;
    bn = 0; ce_cnt = 0;
    reg_wr(3'd0, 32'h800100FF);
    wait_done(cyc);
    chk_byte(0, {2'b10, 8'hFF}, "R7 reset cmd byte");
    check(ce_cnt == 0, "R7 reset without ce", ce_cnt, 0);
  endtask

  task automatic t_timing;
    int cyc;
    bn = 0;
    reg_wr(3'd5, 32'h05101083);
    wel_cnt = 0;
    reg_wr(3'd0, 32'h8009D060);
    wait_done(cyc);
    check(cyc == 30, "R6 busy cycles", cyc, 30);
    check(wel_cnt == 8, "R6 strobe low width", wel_cnt, 8);
  endtask

  task automatic t_busy_write;
    int cyc;
    logic [31:0] v;
    bn = 0;
    reg_wr(3'd0, 32'h8009D060);
    reg_wr(3'd0, 32'h80010011);
    reg_wr(3'd1, 32'h5555);
    wait_done(cyc);
    check(bn == 2, "R9 ignored ctl no extra bytes", bn, 2);
    chk_byte(1, {2'b10, 8'hD0}, "R9 original op");
    reg_rd(3'd0, v);
    check(v[7:0] == 8'h60, "R9 ctl unchanged", v[7:0], 8'h60);
    check(v[27] == 1'b1, "R9 error latched", v[27], 1);
    reg_rd(3'd1, v);
    check(v == 32'h12AB, "R10 col write ignored", v, 32'h12AB);
    rb = 1'b0;
    repeat (3) @(negedge clk);
    reg_rd(3'd0, v);
    check(v[26:25] == 2'b00 && v[27] == 1'b0, "R8 err masked by busy",
          32'(v[27:26]), 32'h0);
    rb = 1'b1;
    repeat (3) @(negedge clk);
    reg_wr(3'd5, 32'h0);
    reg_wr(3'd0, 32'h80010070);
    wait_done(cyc);
    reg_rd(3'd0, v);
    check(v[27] == 1'b0, "R9 error cleared on start", v[27], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    t_reset();
    t_cmd_addr();
    t_read();
    t_write();
    t_special();
    t_reset_cmd();
    t_timing();
    t_busy_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule